// File: doc/BRIEF.md
# Parallel Bit-Serial Maximum Selector

The block finds which of `NUM_STREAMS` lockstep serial inputs carries the largest `WORD_BITS`-bit unsigned value. Every input presents one bit per clock, most significant bit first, and all inputs advance on the same edge. No word is ever compared against another word. The block keeps one survivor flag per stream and builds a single OR over the current bits of the streams that still survive. A survivor that shows a 0 while some other survivor shows a 1 is dropped. A survivor that shows a 1 is always kept. If no survivor shows a 1, nobody is dropped.

A scan opens with a one-cycle `start_i` pulse, which sets every flag. That cycle is followed by `WORD_BITS` bit cycles, so a fresh result is available every `WORD_BITS + 1` clocks. When the last bit has been taken in, `done_o` rises. The survivor mask, the index of the lowest-numbered survivor and a valid flag then stay unchanged until the next start. When several streams tie at the maximum, all of them remain in the mask and the index names the lowest one.

Top module: `bsmax_select`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle: after that edge `done_o` is 0 and `cand_o` is all ones.
- R2: A `start_i` pulse sampled at an edge sets every bit of `cand_o` and clears `done_o`. The `bits_i` value in the start cycle is ignored.
- R3: In the bit cycles, bit `i` of `bits_i` is bit `WORD_BITS-1-j` of stream `i`'s word in the j-th bit cycle after start (MSB first). A survivor whose current bit is 1 stays a survivor.
- R4: A survivor whose current bit is 0 is dropped exactly when at least one survivor has a current bit of 1. Otherwise it is kept.
- R5: `done_o` is 0 through the first `WORD_BITS-1` bit edges and goes to 1 right after the edge that takes in the `WORD_BITS`-th bit.
- R6: While `done_o` is 1 and no start is given, `cand_o`, `win_idx_o` and `done_o` hold, whatever `bits_i` does.
- R7: When `done_o` is 1, `cand_o` has bit `i` set exactly for the streams whose word equals the largest word. Ties leave several bits set.
- R8: `win_idx_o` is the lowest index whose `cand_o` bit is set. `win_valid_o` is 1 exactly when `done_o` is 1 and `cand_o` is nonzero.
- R9: A `start_i` that arrives in the cycle of the last bit takes priority. No result is produced, `done_o` stays 0 and a new scan begins with all flags set.
- R10: `rst` overrides a simultaneous `start_i`. After it, the block stays idle with `done_o` at 0 until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that opens a scan |
| bits_i | input | NUM_STREAMS | Current bit of every stream |
| cand_o | output | NUM_STREAMS | Survivor mask |
| win_idx_o | output | $clog2(NUM_STREAMS) | Index of the lowest-numbered survivor |
| win_valid_o | output | 1 | Result valid (done and some survivor) |
| done_o | output | 1 | All bits of the current scan taken in |

## Verification
Two events can fall into the same cycle: the last bit of a scan and a new start pulse. A third case is a reset together with a start. The bench raises `start_i` while it presents the final bit and expects `done_o` to stay low, the mask to return to all ones, and a complete second scan to produce the correct result. It also raises `rst` and `start_i` together partway through a scan. In that case it expects the block to stay idle with `done_o` low for longer than a whole scan would take.

// File: rtl/bsmax_pkg.sv
package bsmax_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_SCAN = 2'd1,
        PH_DONE = 2'd2
    } phase_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned cnt_width(input int unsigned k);
        return (k <= 1) ? 1 : $clog2(k);
    endfunction

endpackage

// File: rtl/bsmax_seq.sv
module bsmax_seq
    import bsmax_pkg::*;
#(
    parameter int unsigned WORD_BITS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic load_o,
    output logic step_o,
    output logic done_o
);
    localparam int unsigned CW = cnt_width(WORD_BITS);
    localparam logic [CW-1:0] LAST = CW'(WORD_BITS - 1);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;

    assign load_o = start_i & ~rst;
    assign step_o = (phase_q == PH_SCAN) & ~start_i & ~rst;
    assign done_o = (phase_q == PH_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else if (start_i) begin
            phase_q <= PH_SCAN;
            cnt_q   <= '0;
        end else if (phase_q == PH_SCAN) begin
            if (cnt_q == LAST) begin
                phase_q <= PH_DONE;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    // R5: done may only appear straight out of a scan
    p_done_from_scan_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> $past(phase_q == PH_SCAN && cnt_q == LAST));

    // R9: a start always yields a scan with no result
    p_start_wins_r9: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (phase_q == PH_SCAN) && !done_o);

endmodule

// File: rtl/bsmax_cand_array.sv
module bsmax_cand_array #(
    parameter int unsigned NUM_STREAMS = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load_i,
    input  logic                   step_i,
    input  logic [NUM_STREAMS-1:0] bits_i,
    output logic [NUM_STREAMS-1:0] cand_o
);
    logic [NUM_STREAMS-1:0] cand_q;
    logic [NUM_STREAMS-1:0] live_hot;
    logic                   any_hot;

    assign live_hot = cand_q & bits_i;
    assign any_hot  = |live_hot;

    for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst || load_i) begin
                cand_q[g] <= 1'b1;
            end else if (step_i) begin
                cand_q[g] <= cand_q[g] & (bits_i[g] | ~any_hot);
            end
        end
    end

    assign cand_o = cand_q;

    // R3: a survivor showing a 1 is never dropped
    p_keep_hot_r3: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i) |=> (($past(live_hot) & ~cand_q) == '0));

    // R4: with some survivor hot, exactly the hot survivors remain
    p_drop_cold_r4: assert property (@(posedge clk) disable iff (rst)
        (step_i && any_hot) |=> (cand_q == $past(live_hot)));

    // R4: with no survivor hot, nothing changes
    p_no_hot_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (step_i && !any_hot) |=> $stable(cand_q));

    // R2: start sets every flag
    p_load_all_r2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (&cand_q));

endmodule

// File: rtl/bsmax_lowest_enc.sv
module bsmax_lowest_enc #(
    parameter int unsigned NUM_STREAMS = 16,
    parameter int unsigned IDX_W       = 4
) (
    input  logic [NUM_STREAMS-1:0] req_i,
    output logic [IDX_W-1:0]       idx_o,
    output logic                   any_o
);
    always_comb begin
        idx_o = '0;
        for (int i = NUM_STREAMS - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/bsmax_select.sv
module bsmax_select
    import bsmax_pkg::*;
#(
    parameter int unsigned NUM_STREAMS = 16,
    parameter int unsigned WORD_BITS   = 8,
    localparam int unsigned IDX_W      = idx_width(NUM_STREAMS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic [NUM_STREAMS-1:0] bits_i,
    output logic [NUM_STREAMS-1:0] cand_o,
    output logic [IDX_W-1:0]       win_idx_o,
    output logic                   win_valid_o,
    output logic                   done_o
);
    localparam logic [NUM_STREAMS-1:0] ONE = NUM_STREAMS'(1);

    logic load, step, any_cand;

    bsmax_seq #(.WORD_BITS(WORD_BITS)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .load_o  (load),
        .step_o  (step),
        .done_o  (done_o)
    );

    bsmax_cand_array #(.NUM_STREAMS(NUM_STREAMS)) u_cand (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .step_i (step),
        .bits_i (bits_i),
        .cand_o (cand_o)
    );

    bsmax_lowest_enc #(.NUM_STREAMS(NUM_STREAMS), .IDX_W(IDX_W)) u_enc (
        .req_i (cand_o),
        .idx_o (win_idx_o),
        .any_o (any_cand)
    );

    assign win_valid_o = done_o & any_cand;

    // R8: reported index is set and nothing below it is
    p_lowest_idx_r8: assert property (@(posedge clk) disable iff (rst)
        win_valid_o |-> (cand_o[win_idx_o] &&
                         ((cand_o & ((ONE << win_idx_o) - ONE)) == '0)));

    // R6: result holds until a new start
    p_hold_result_r6: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (done_o && $stable(cand_o)));

    // R7: the survivor set is never empty
    p_never_empty_r7: assert property (@(posedge clk) disable iff (rst)
        any_cand);

    // R1: reset brings the block to idle
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!done_o && (&cand_o)));

endmodule

// File: tb/tb_bsmax_select.sv
module tb_bsmax_select;
    localparam int N  = 16;
    localparam int K  = 8;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [N-1:0]  bits_i = '0;
    logic [N-1:0]  cand_o;
    logic [IW-1:0] win_idx_o;
    logic          win_valid_o;
    logic          done_o;

    int total = 0;
    int bad   = 0;

    logic [K-1:0] words [N];

    always #2.5 clk = ~clk;

    bsmax_select #(.NUM_STREAMS(N), .WORD_BITS(K)) dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .bits_i      (bits_i),
        .cand_o      (cand_o),
        .win_idx_o   (win_idx_o),
        .win_valid_o (win_valid_o),
        .done_o      (done_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [N-1:0] max_mask();
        logic [K-1:0] m = '0;
        logic [N-1:0] r = '0;
        for (int i = 0; i < N; i++) if (words[i] > m) m = words[i];
        for (int i = 0; i < N; i++) r[i] = (words[i] == m);
        return r;
    endfunction

    function automatic logic [IW-1:0] lowest(input logic [N-1:0] m);
        logic [IW-1:0] r = '0;
        for (int i = N - 1; i >= 0; i--) if (m[i]) r = IW'(i);
        return r;
    endfunction

    function automatic logic [N-1:0] bit_slice(input int b);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = words[i][b];
        return r;
    endfunction

    // start pulse with a junk pattern on bits_i, then all K bits, then hold check
    task automatic scan_and_check(input string tag);
        logic [N-1:0] exp_mask = max_mask();
        logic [N-1:0] msb = bit_slice(K - 1);
        logic [N-1:0] snap;
        start_i = 1'b1;
        bits_i  = 16'h5A3C;
        tick();
        start_i = 1'b0;
        check({"R2 ", tag, " flags set after start"}, 32'(cand_o), 32'(16'hFFFF));
        check({"R2 ", tag, " done cleared"}, 32'(done_o), 32'd0);
        for (int b = K - 1; b >= 0; b--) begin
            bits_i = bit_slice(b);
            if (b == 0) check({"R5 ", tag, " done low before last bit"}, 32'(done_o), 32'd0);
            tick();
            if (b == K - 1)
                check({"R4 ", tag, " survivors after MSB"}, 32'(cand_o),
                      32'((msb != '0) ? msb : 16'hFFFF));
        end
        check({"R5 ", tag, " done after last bit"}, 32'(done_o), 32'd1);
        check({"R7 ", tag, " survivor mask"}, 32'(cand_o), 32'(exp_mask));
        check({"R8 ", tag, " lowest index"}, 32'(win_idx_o), 32'(lowest(exp_mask)));
        check({"R8 ", tag, " valid"}, 32'(win_valid_o), 32'd1);
        snap = cand_o;
        for (int c = 0; c < 3; c++) begin
            bits_i = ~bits_i ^ 16'(c * 16'h1111);
            tick();
        end
        check({"R6 ", tag, " mask held"}, 32'(cand_o), 32'(snap));
        check({"R6 ", tag, " done held"}, 32'(done_o), 32'd1);
        check({"R6 ", tag, " index held"}, 32'(win_idx_o), 32'(lowest(exp_mask)));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        tick(); tick();
        check("R1 done after reset", 32'(done_o), 32'd0);
        check("R1 mask after reset", 32'(cand_o), 32'(16'hFFFF));
        check("R8 valid low after reset", 32'(win_valid_o), 32'd0);
        rst = 1'b0;
        tick();
    endtask

    task automatic t_distinct();
        for (int i = 0; i < N; i++) words[i] = 8'(i * 13 + 7);
        scan_and_check("distinct R3");
    endtask

    task automatic t_duplicates();
        for (int i = 0; i < N; i++) words[i] = 8'(i * 5);
        words[3] = 8'hC8; words[9] = 8'hC8; words[14] = 8'hC8; words[6] = 8'hC7;
        scan_and_check("ties R7");
    endtask

    task automatic t_all_zero();
        for (int i = 0; i < N; i++) words[i] = '0;
        scan_and_check("all zero R4");
    endtask

    task automatic t_top_stream();
        for (int i = 0; i < N; i++) words[i] = 8'h7F;
        words[15] = 8'h80;
        scan_and_check("top stream R3");
    endtask

    task automatic t_start_collision();
        for (int i = 0; i < N; i++) words[i] = 8'(255 - i * 11);
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        for (int b = K - 1; b >= 1; b--) begin
            bits_i = bit_slice(b);
            tick();
        end
        bits_i  = bit_slice(0);
        start_i = 1'b1;
        tick();
        check("R9 done stays low on start collision", 32'(done_o), 32'd0);
        check("R9 flags reset on collision", 32'(cand_o), 32'(16'hFFFF));
        start_i = 1'b0;
        for (int b = K - 1; b >= 0; b--) begin
            bits_i = bit_slice(b);
            tick();
        end
        check("R9 scan after collision done", 32'(done_o), 32'd1);
        check("R9 scan after collision mask", 32'(cand_o), 32'(max_mask()));
    endtask

    task automatic t_reset_with_start();
        for (int i = 0; i < N; i++) words[i] = 8'(i * 3 + 1);
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        for (int b = K - 1; b >= K - 3; b--) begin
            bits_i = bit_slice(b);
            tick();
        end
        rst = 1'b1; start_i = 1'b1;
        tick();
        rst = 1'b0; start_i = 1'b0;
        check("R10 mask after reset plus start", 32'(cand_o), 32'(16'hFFFF));
        for (int c = 0; c < K + 2; c++) begin
            bits_i = 16'(c * 16'h0F0F);
            tick();
        end
        check("R10 stays idle", 32'(done_o), 32'd0);
        check("R10 valid low while idle", 32'(win_valid_o), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1;
        t_reset();
        t_distinct();
        t_duplicates();
        t_all_zero();
        t_top_stream();
        t_start_collision();
        t_reset_with_start();
        t_distinct();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule